// File: doc/BRIEF.md
# Daisy-Chainable Interrupt Priority Resolver

The resolver picks one interrupt to present from up to 32 local request lines and one request arriving on a chain input from an upstream resolver. Each local line carries a requested level and a per-port enable. The chain input carries a level, a vector number and an auxiliary field. A pipelined comparison tree chooses the highest level. A registered output stage then presents the winner toward the processor, or toward the chain input of the next resolver downstream.

If a local port wins, the output vector is the port number. If the chain input wins, its vector and auxiliary fields are forwarded untouched, so a long chain of resolvers behaves as one wide priority selector. The tree is given 1, 2 or 3 register stages, chosen from the configured port count. One output register follows it. A new set of inputs is accepted on every clock.

Top module: `irq_prio_resolver`

## Requirements
- R1: The output level is the highest effective level among the enabled local ports and the chain input, and that input is the winner.
- R2: On equal levels the lowest-numbered local port wins, and any local port beats the chain input at the same level.
- R3: A port whose enable bit is 0 counts as level 0, whatever level it presents.
- R4: When a local port wins, `irq_vec_o` holds its port number, zero-extended, and `irq_aux_o` is 0.
- R5: When the chain input wins, `irq_vec_o` and `irq_aux_o` equal `chain_vec_i` and `chain_aux_i` as sampled, and `irq_ril_o` is the truncated chain level.
- R6: Only the low `RIL_W` bits of `chain_ril_i` are used. A chain level whose low bits are all zero is no request.
- R7: Level 0 means no request. When no input requests, `irq_vld_o` is 0 and `irq_ril_o`, `irq_vec_o` and `irq_aux_o` are all 0.
- R8: A result appears after L = S+1 rising edges. The first of these edges is the one that samples the inputs. S is 1 for 2 to 4 ports, 2 for 5 to 16 ports and 3 for 17 to 32 ports. The output does not change before that edge.
- R9: The inputs may change on every cycle, and each input set yields its own result exactly L edges later.
- R10: While `rst_ni` is low, all outputs are 0 at once, without waiting for a clock edge.
- R11: A resolver built with fewer than 32 ports (for example 3 or 10) accepts the chain input and resolves it under R1 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ril_i | input | NUM_PORTS*RIL_W | Level of each local port; port i occupies bits [i*RIL_W +: RIL_W] |
| req_en_i | input | NUM_PORTS | Enable of each local port; bit i is port i |
| chain_ril_i | input | CHAIN_RIL_W | Level from the upstream resolver |
| chain_vec_i | input | VEC_W | Vector number from the upstream resolver |
| chain_aux_i | input | AUX_W | Auxiliary field from the upstream resolver |
| irq_vld_o | output | 1 | A request is being presented |
| irq_ril_o | output | RIL_W | Level of the winning request |
| irq_vec_o | output | VEC_W | Vector of the winning request |
| irq_aux_o | output | AUX_W | Auxiliary field; non-zero only for a chain winner |

## Verification
Two things can happen in the same cycle: a local port and the chain input can present equal levels, and the chain level can be truncated. The bench drives a chain level equal to a local level, then a wide chain level that truncates to zero. It judges the result from `irq_vec_o` and `irq_aux_o`, because the two possible winners give different values there. A streamed sequence changes every input on every cycle. Three resolver widths share that stimulus, so a result emerging at the output while newer inputs are sampled is checked at each width's own latency.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // register stages inside the comparison tree for a given port count
  function automatic int prio_stages(int n_ports);
    if (n_ports <= 4) return 1;
    if (n_ports <= 16) return 2;
    return 3;
  endfunction

  // depth of heap node k (root is 0)
  function automatic int node_depth(int k);
    int d;
    int v;
    d = 0;
    v = k + 1;
    while (v > 1) begin
      v = v >> 1;
      d = d + 1;
    end
    return d;
  endfunction

  // is tree level lvl (0 = leaves) followed by a register; stages spread evenly, root always
  function automatic bit is_stage_reg(int lvl, int top, int stages);
    for (int j = 1; j <= stages; j++) begin
      if (lvl == (top * j + stages - 1) / stages) return 1'b1;
    end
    return 1'b0;
  endfunction

endpackage

// File: rtl/irq_leaf_qual.sv
module irq_leaf_qual #(
  parameter int NUM_PORTS   = 32,
  parameter int RIL_W       = 6,
  parameter int CHAIN_RIL_W = 8,
  parameter int IDX_W       = 5,
  localparam int NW         = 1 + IDX_W + RIL_W,
  localparam int N_LEAF     = NUM_PORTS + 1
) (
  input  logic [NUM_PORTS*RIL_W-1:0] req_ril_i,
  input  logic [NUM_PORTS-1:0]       req_en_i,
  input  logic [CHAIN_RIL_W-1:0]     chain_ril_i,
  output logic [N_LEAF*NW-1:0]       leaves_o
);

  // leaf = {from_chain, index, level}
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic [RIL_W-1:0] eff;
    assign eff = req_en_i[i] ? req_ril_i[i*RIL_W +: RIL_W] : '0;
    assign leaves_o[i*NW +: NW] = {1'b0, IDX_W'(i), eff};
  end

  // chain leaf sits after all ports so local ports win ties
  assign leaves_o[NUM_PORTS*NW +: NW] = {1'b1, {IDX_W{1'b0}}, chain_ril_i[RIL_W-1:0]};

  if (CHAIN_RIL_W > RIL_W) begin : g_drop
    logic unused_hi;
    assign unused_hi = ^chain_ril_i[CHAIN_RIL_W-1:RIL_W];
  end

endmodule

// File: rtl/irq_cmp_tree.sv
module irq_cmp_tree
  import irq_prio_pkg::*;
#(
  parameter int N_LEAF = 33,
  parameter int RIL_W  = 6,
  parameter int IDX_W  = 5,
  parameter int STAGES = 3,
  localparam int NW    = 1 + IDX_W + RIL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_LEAF*NW-1:0] leaves_i,
  output logic [NW-1:0]        win_o
);

  localparam int LVL    = $clog2(N_LEAF);
  localparam int P2     = 1 << LVL;
  localparam int N_NODE = 2 * P2 - 1;

  logic [NW-1:0] tree [N_NODE];

  for (genvar i = 0; i < P2; i++) begin : g_leaf
    if (i < N_LEAF) begin : g_real
      assign tree[P2-1+i] = leaves_i[i*NW +: NW];
    end else begin : g_pad
      assign tree[P2-1+i] = '0;
    end
  end

  for (genvar k = 0; k < P2 - 1; k++) begin : g_node
    logic [NW-1:0] lhs, rhs, pick;
    assign lhs  = tree[2*k+1];
    assign rhs  = tree[2*k+2];
    // left (lower position) keeps ties
    assign pick = (lhs[RIL_W-1:0] >= rhs[RIL_W-1:0]) ? lhs : rhs;

    if (is_stage_reg(LVL - node_depth(k), LVL, STAGES)) begin : g_reg
      logic [NW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= pick;
      end
      assign tree[k] = q;
    end else begin : g_comb
      assign tree[k] = pick;
    end
  end

  assign win_o = tree[0];

endmodule

// File: rtl/irq_delay_line.sv
module irq_delay_line #(
  parameter int W     = 12,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[DEPTH-1];

endmodule

// File: rtl/irq_vec_out.sv
module irq_vec_out #(
  parameter int RIL_W = 6,
  parameter int IDX_W = 5,
  parameter int VEC_W = 8,
  parameter int AUX_W = 4,
  localparam int NW   = 1 + IDX_W + RIL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NW-1:0]    win_i,
  input  logic [VEC_W-1:0] chain_vec_i,
  input  logic [AUX_W-1:0] chain_aux_i,
  output logic             vld_o,
  output logic [RIL_W-1:0] ril_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [AUX_W-1:0] aux_o,
  output logic             from_chain_o
);

  logic [RIL_W-1:0] w_ril;
  logic [IDX_W-1:0] w_idx;
  logic             w_chain;
  logic             nxt_vld, nxt_chain;
  logic [VEC_W-1:0] nxt_vec;
  logic [AUX_W-1:0] nxt_aux;

  assign w_ril   = win_i[RIL_W-1:0];
  assign w_idx   = win_i[RIL_W +: IDX_W];
  assign w_chain = win_i[NW-1];

  always_comb begin
    nxt_vld   = (w_ril != '0);
    nxt_chain = 1'b0;
    nxt_vec   = '0;
    nxt_aux   = '0;
    if (nxt_vld) begin
      if (w_chain) begin
        nxt_chain = 1'b1;
        nxt_vec   = chain_vec_i;
        nxt_aux   = chain_aux_i;
      end else begin
        nxt_vec   = VEC_W'(w_idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      ril_o        <= '0;
      vec_o        <= '0;
      aux_o        <= '0;
      from_chain_o <= 1'b0;
    end else begin
      vld_o        <= nxt_vld;
      ril_o        <= w_ril;
      vec_o        <= nxt_vec;
      aux_o        <= nxt_aux;
      from_chain_o <= nxt_chain;
    end
  end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int NUM_PORTS   = 32,
  parameter int RIL_W       = 6,
  parameter int CHAIN_RIL_W = 8,
  parameter int VEC_W       = 8,
  parameter int AUX_W       = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PORTS*RIL_W-1:0] req_ril_i,
  input  logic [NUM_PORTS-1:0]       req_en_i,
  input  logic [CHAIN_RIL_W-1:0]     chain_ril_i,
  input  logic [VEC_W-1:0]           chain_vec_i,
  input  logic [AUX_W-1:0]           chain_aux_i,
  output logic                       irq_vld_o,
  output logic [RIL_W-1:0]           irq_ril_o,
  output logic [VEC_W-1:0]           irq_vec_o,
  output logic [AUX_W-1:0]           irq_aux_o
);

  localparam int IDX_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int NW     = 1 + IDX_W + RIL_W;
  localparam int N_LEAF = NUM_PORTS + 1;
  localparam int STAGES = prio_stages(NUM_PORTS);
  localparam int CF_W   = VEC_W + AUX_W;

  logic [N_LEAF*NW-1:0] leaves;
  logic [NW-1:0]        win;
  logic [CF_W-1:0]      cf_q;
  logic                 from_chain;

  irq_leaf_qual #(
    .NUM_PORTS(NUM_PORTS), .RIL_W(RIL_W), .CHAIN_RIL_W(CHAIN_RIL_W), .IDX_W(IDX_W)
  ) u_qual (
    .req_ril_i  (req_ril_i),
    .req_en_i   (req_en_i),
    .chain_ril_i(chain_ril_i),
    .leaves_o   (leaves)
  );

  irq_cmp_tree #(
    .N_LEAF(N_LEAF), .RIL_W(RIL_W), .IDX_W(IDX_W), .STAGES(STAGES)
  ) u_tree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .leaves_i(leaves),
    .win_o   (win)
  );

  // chain fields travel beside the tree so they meet their own level
  irq_delay_line #(.W(CF_W), .DEPTH(STAGES)) u_cf_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({chain_vec_i, chain_aux_i}),
    .q_o   (cf_q)
  );

  irq_vec_out #(
    .RIL_W(RIL_W), .IDX_W(IDX_W), .VEC_W(VEC_W), .AUX_W(AUX_W)
  ) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_i       (win),
    .chain_vec_i (cf_q[CF_W-1:AUX_W]),
    .chain_aux_i (cf_q[AUX_W-1:0]),
    .vld_o       (irq_vld_o),
    .ril_o       (irq_ril_o),
    .vec_o       (irq_vec_o),
    .aux_o       (irq_aux_o),
    .from_chain_o(from_chain)
  );

endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk
  import irq_prio_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int RIL_W     = 6,
  parameter int VEC_W     = 8,
  parameter int AUX_W     = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_PORTS*RIL_W-1:0] req_ril_i,
  input logic [NUM_PORTS-1:0]       req_en_i,
  input logic [RIL_W-1:0]           chain_lo_i,
  input logic [VEC_W-1:0]           chain_vec_i,
  input logic [AUX_W-1:0]           chain_aux_i,
  input logic                       irq_vld_o,
  input logic [RIL_W-1:0]           irq_ril_o,
  input logic [VEC_W-1:0]           irq_vec_o,
  input logic [AUX_W-1:0]           irq_aux_o,
  input logic                       from_chain_i
);

  localparam int LAT = prio_stages(NUM_PORTS) + 1;

  logic       any_req;
  logic [RIL_W-1:0] p0_eff;
  logic [2:0] since_rst;

  always_comb begin
    any_req = (chain_lo_i != '0);
    for (int i = 0; i < NUM_PORTS; i++)
      if (req_en_i[i] && (req_ril_i[i*RIL_W +: RIL_W] != '0)) any_req = 1'b1;
  end

  assign p0_eff = req_en_i[0] ? req_ril_i[RIL_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst <= '0;
    else if (since_rst < 3'(LAT)) since_rst <= since_rst + 3'd1;
  end

  AST_VLD_TRACKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'(LAT)) |-> (irq_vld_o == $past(any_req, LAT))); // R8

  AST_RIL_GE_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'(LAT)) |-> (irq_ril_o >= $past(chain_lo_i, LAT))); // R1

  AST_RIL_GE_PORT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'(LAT)) |-> (irq_ril_o >= $past(p0_eff, LAT))); // R3

  AST_CHAIN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'(LAT)) && from_chain_i |->
      (irq_vec_o == $past(chain_vec_i, LAT)) && (irq_aux_o == $past(chain_aux_i, LAT))
      && (irq_ril_o == $past(chain_lo_i, LAT))); // R5

  AST_LOCAL_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_vld_o && !from_chain_i |-> (irq_aux_o == '0) && (irq_vec_o < VEC_W'(NUM_PORTS))); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_vld_o |-> (irq_ril_o == '0) && (irq_vec_o == '0) && (irq_aux_o == '0) && !from_chain_i); // R7

endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(
  .NUM_PORTS(NUM_PORTS), .RIL_W(RIL_W), .VEC_W(VEC_W), .AUX_W(AUX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ril_i   (req_ril_i),
  .req_en_i    (req_en_i),
  .chain_lo_i  (chain_ril_i[RIL_W-1:0]),
  .chain_vec_i (chain_vec_i),
  .chain_aux_i (chain_aux_i),
  .irq_vld_o   (irq_vld_o),
  .irq_ril_o   (irq_ril_o),
  .irq_vec_o   (irq_vec_o),
  .irq_aux_o   (irq_aux_o),
  .from_chain_i(from_chain)
);

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int RW = 6;
  localparam int OW = 1 + RW + 8 + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP*RW-1:0] req_ril;
  logic [NP-1:0]    req_en;
  logic [7:0]       chain_ril;
  logic [7:0]       chain_vec;
  logic [3:0]       chain_aux;

  logic [OW-1:0] out_b, out_m, out_s;
  logic       vb, vm, vs;
  logic [5:0] rb, rm, rs;
  logic [7:0] eb, em, es;
  logic [3:0] ab, am, as_;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_resolver uut (
    .clk_i(clk), .rst_ni(rst_n), .req_ril_i(req_ril), .req_en_i(req_en),
    .chain_ril_i(chain_ril), .chain_vec_i(chain_vec), .chain_aux_i(chain_aux),
    .irq_vld_o(vb), .irq_ril_o(rb), .irq_vec_o(eb), .irq_aux_o(ab));

  irq_prio_resolver #(.NUM_PORTS(10)) uut_mid (
    .clk_i(clk), .rst_ni(rst_n), .req_ril_i(req_ril[10*RW-1:0]), .req_en_i(req_en[9:0]),
    .chain_ril_i(chain_ril), .chain_vec_i(chain_vec), .chain_aux_i(chain_aux),
    .irq_vld_o(vm), .irq_ril_o(rm), .irq_vec_o(em), .irq_aux_o(am));

  irq_prio_resolver #(.NUM_PORTS(3)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .req_ril_i(req_ril[3*RW-1:0]), .req_en_i(req_en[2:0]),
    .chain_ril_i(chain_ril), .chain_vec_i(chain_vec), .chain_aux_i(chain_aux),
    .irq_vld_o(vs), .irq_ril_o(rs), .irq_vec_o(es), .irq_aux_o(as_));

  assign out_b = {vb, rb, eb, ab};
  assign out_m = {vm, rm, em, am};
  assign out_s = {vs, rs, es, as_};

  function automatic logic [OW-1:0] model(int n);
    int best;
    int bi;
    logic [5:0] r;
    best = 0;
    bi = 0;
    for (int i = 0; i < n; i++) begin
      r = req_en[i] ? req_ril[i*RW +: RW] : 6'd0;
      if (int'(r) > best) begin best = int'(r); bi = i; end
    end
    if (int'(chain_ril[5:0]) > best) return {1'b1, chain_ril[5:0], chain_vec, chain_aux};
    if (best == 0) return '0;
    return {1'b1, 6'(best), 8'(bi), 4'h0};
  endfunction

  task automatic check(string req, string who, logic [OW-1:0] act, logic [OW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: act vld=%0b ril=%0d vec=%0d aux=%0d exp vld=%0b ril=%0d vec=%0d aux=%0d",
               req, who, act[18], act[17:12], act[11:4], act[3:0],
               exp[18], exp[17:12], exp[11:4], exp[3:0]);
    end
  endtask

  task automatic check_all(string req);
    check(req, "p32", out_b, model(32));
    check(req, "p10", out_m, model(10));
    check(req, "p3",  out_s, model(3));
  endtask

  task automatic clear_in();
    req_ril = '0;
    req_en = '0;
    chain_ril = '0;
    chain_vec = '0;
    chain_aux = '0;
  endtask

  task automatic set_port(int i, int ril, bit en);
    req_ril[i*RW +: RW] = 6'(ril);
    req_en[i] = en;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_in();
    set_port(0, 9, 1);
    repeat (3) @(negedge clk);
    check("R10", "p32", out_b, '0);
    check("R10", "p3", out_s, '0);
    rst_n = 1'b1;
    settle();
    check_all("R1");
    // asynchronous reset while a request is presented
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", "p32", out_b, '0);
    check("R10", "p10", out_m, '0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_in();
    settle();
    check_all("R7");
  endtask

  task automatic t_highest();
    clear_in();
    set_port(2, 3, 1); set_port(7, 20, 1); set_port(20, 40, 1);
    settle();
    check_all("R1");
    clear_in();
    set_port(5, 9, 1);
    settle();
    check_all("R4");
    check("R4", "p32", out_b, {1'b1, 6'd9, 8'd5, 4'd0});
  endtask

  task automatic t_tie();
    clear_in();
    set_port(1, 12, 1); set_port(6, 12, 1); set_port(25, 12, 1);
    settle();
    check_all("R2");
    check("R2", "p32", out_b, {1'b1, 6'd12, 8'd1, 4'd0});
    clear_in();
    set_port(4, 15, 1);
    chain_ril = 8'd15; chain_vec = 8'hC3; chain_aux = 4'h6;
    settle();
    check("R2", "p32", out_b, {1'b1, 6'd15, 8'd4, 4'd0});
    check("R2", "p10", out_m, {1'b1, 6'd15, 8'd4, 4'd0});
    check("R11", "p3", out_s, {1'b1, 6'd15, 8'hC3, 4'h6});
  endtask

  task automatic t_disable();
    clear_in();
    set_port(3, 50, 0); set_port(9, 10, 1);
    settle();
    check_all("R3");
    check("R3", "p32", out_b, {1'b1, 6'd10, 8'd9, 4'd0});
    clear_in();
    set_port(0, 63, 0); set_port(31, 40, 0);
    settle();
    check("R3", "p32", out_b, '0);
    check_all("R3");
  endtask

  task automatic t_chain();
    clear_in();
    set_port(2, 30, 1); set_port(8, 31, 1); set_port(30, 33, 1);
    chain_ril = 8'h3F; chain_vec = 8'hA5; chain_aux = 4'h9;
    settle();
    check_all("R5");
    check("R11", "p10", out_m, {1'b1, 6'd63, 8'hA5, 4'h9});
    check("R5", "p32", out_b, {1'b1, 6'd63, 8'hA5, 4'h9});
  endtask

  task automatic t_trunc();
    clear_in();
    chain_ril = 8'hC0; chain_vec = 8'h11; chain_aux = 4'h2;
    settle();
    check("R6", "p32", out_b, '0);
    check_all("R6");
    set_port(0, 4, 1);
    chain_ril = 8'h85;
    settle();
    check("R6", "p32", out_b, {1'b1, 6'd5, 8'h11, 4'h2});
    check_all("R6");
  endtask

  task automatic t_latency();
    clear_in();
    settle();
    set_port(0, 7, 1);
    for (int e = 1; e <= 5; e++) begin
      @(posedge clk);
      @(negedge clk);
      check("R8", "p32", {31'd0, vb}, {31'd0, (e >= 4)});
      check("R8", "p10", {31'd0, vm}, {31'd0, (e >= 3)});
      check("R8", "p3",  {31'd0, vs}, {31'd0, (e >= 2)});
    end
  endtask

  task automatic t_stream();
    localparam int K = 24;
    logic [OW-1:0] hb [K];
    logic [OW-1:0] hm [K];
    logic [OW-1:0] hs [K];
    void'($urandom(7));
    for (int j = 0; j < K + 4; j++) begin
      @(negedge clk);
      if (j >= 4 && j - 4 < K) check("R9", "p32", out_b, hb[j-4]);
      if (j >= 3 && j - 3 < K) check("R9", "p10", out_m, hm[j-3]);
      if (j >= 2 && j - 2 < K) check("R9", "p3",  out_s, hs[j-2]);
      if (j < K) begin
        for (int i = 0; i < NP; i++) begin
          req_ril[i*RW +: RW] = ($urandom % 3 == 0) ? 6'($urandom % 16) : 6'd0;
          req_en[i] = ($urandom % 4 != 0);
        end
        chain_ril = 8'($urandom);
        chain_vec = 8'($urandom);
        chain_aux = 4'($urandom);
        hb[j] = model(32);
        hm[j] = model(10);
        hs[j] = model(3);
      end
    end
  endtask

  initial begin
    clear_in();
    t_reset();
    t_highest();
    t_tie();
    t_disable();
    t_chain();
    t_trunc();
    t_latency();
    t_stream();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule